// File: doc/BRIEF.md
# Output Departure Timestamp Allocator

This block stamps every flit that arrives at a router input with the future clock cycle on which that flit is allowed to leave the shared buffer toward its chosen output. The stamps for a given output come out in arrival order. The router therefore reproduces the first-come-first-served service of an ideal output-queued router without having to win a switch arbitration each cycle. Only one flit can leave an output per cycle, so no two flits bound for the same output ever receive the same stamp.

Each output keeps a register holding its next free departure cycle. A new flit gets the later of two values: that register, or the current cycle plus the minimum pipeline depth. When several inputs name the same output in one cycle, they receive consecutive stamps, lowest input index first. Stamps are held modulo 2^TS_W and compared with wrap-safe arithmetic. An idle output's register is pulled forward every cycle so that it never falls outside the comparison window.

A later stage may reject a flit. The rejected flit simply requests again and receives a fresh, later stamp. Slots that were handed out before the rejection are not reclaimed; they stay idle.

Top module: `tsa_alloc`

## Requirements
- R1: While reset is high, and in the cycle after it is released, every `ts_valid` bit is 0. The first request after reset receives the current cycle plus `MIN_LAT`, whatever value `cur_time` had during reset.
- R2: A request presented on input i in one cycle produces `ts_valid[i]` and `ts_value[i*TS_W +: TS_W]` on the following cycle, computed from `cur_time` as sampled together with the request. Inputs with no request show `ts_valid` 0.
- R3: A flit bound for an output with no backlog receives `cur_time + MIN_LAT`, modulo 2^TS_W. This holds even after that output has been idle for longer than half the timestamp range.
- R4: Inputs that name the same output in the same cycle receive consecutive stamps starting at that output's base value, in increasing input-index order.
- R5: After stamps have been granted, an output's next stamp is the last granted value plus 1 whenever that is later than `cur_time + MIN_LAT`. Stamps already issued, including those of flits that later re-request, are never issued again.
- R6: Requests to different outputs in the same cycle do not influence each other's stamps.
- R7: Comparisons are modulo 2^TS_W. A backlog whose stamps have wrapped past zero still counts as later than a non-wrapped `cur_time + MIN_LAT`.
- R8: A request whose port field is `NUM_PORTS` or more is ignored. It gives `ts_valid` 0, it does not advance any output, and it does not shift the rank of higher-index requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_time | input | TS_W | Free-running cycle counter, advancing by one per cycle |
| req_valid | input | NUM_PORTS | One request flag per input port |
| req_port | input | NUM_PORTS*PORT_W | Requested output index for each input; field i at bits [i*PORT_W +: PORT_W] |
| ts_valid | output | NUM_PORTS | Stamp valid, one cycle after the request |
| ts_value | output | NUM_PORTS*TS_W | Departure stamp for each input; field i at bits [i*TS_W +: TS_W] |

## Verification
On every cycle, the assertions check the following. Each stamp lies no earlier than the sampling cycle plus `MIN_LAT`. Two requests that shared an output in one cycle come out strictly ordered by input index. A stamp appears only for a legal request, and nothing is valid straight after reset. What the bench scenarios alone can show is history: that a backlog carries over from one cycle to the next with exact +1 spacing, that the order survives a wrap past zero, that a long idle gap returns the output to the floor value, and that illegal port codes leave every output untouched.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    localparam int unsigned TS_MAX_W = 32;

    typedef logic [TS_MAX_W-1:0] ts_wide_t;

    // A modular difference with its top bit set means "a is behind b".
    function automatic logic ts_behind(input ts_wide_t diff, input int unsigned w);
        return diff[w-1];
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/tsa_lane.sv
module tsa_lane
    import tsa_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 5,
    parameter int unsigned TS_W      = 8,
    parameter int unsigned MIN_LAT   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [TS_W-1:0]      cur_time,
    input  logic [NUM_PORTS-1:0] hit,
    output logic [TS_W-1:0]      base
);
    localparam int unsigned CNT_W = cnt_width(NUM_PORTS);

    logic [TS_W-1:0]  next_free_q;
    logic             fresh_q;
    logic [TS_W-1:0]  floor_ts;
    logic [TS_W-1:0]  gap;
    logic [CNT_W-1:0] grants;

    assign floor_ts = cur_time + TS_W'(MIN_LAT);
    assign gap      = next_free_q - floor_ts;
    assign grants   = CNT_W'($countones(hit));

    // Later of the floor and the backlog; right after reset the register is meaningless.
    always_comb begin
        if (fresh_q || ts_behind(ts_wide_t'(gap), TS_W))
            base = floor_ts;
        else
            base = next_free_q;
    end

    // The register is refreshed every cycle, so an idle lane never drifts out of the window.
    always_ff @(posedge clk) begin
        if (rst) begin
            next_free_q <= '0;
            fresh_q     <= 1'b1;
        end else begin
            next_free_q <= base + TS_W'(grants);
            fresh_q     <= 1'b0;
        end
    end

endmodule

// File: rtl/tsa_rank.sv
module tsa_rank #(
    parameter int unsigned NUM_PORTS = 5,
    parameter int unsigned PORT_W    = 3,
    parameter int unsigned CNT_W     = 3
) (
    input  logic [NUM_PORTS-1:0]        legal,
    input  logic [NUM_PORTS*PORT_W-1:0] port,
    output logic [NUM_PORTS*CNT_W-1:0]  rank
);
    // rank of input i = legal lower-index requests that name the same output
    always_comb begin
        rank = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            for (int j = 0; j < i; j++) begin
                if (legal[j] && (port[j*PORT_W +: PORT_W] == port[i*PORT_W +: PORT_W]))
                    rank[i*CNT_W +: CNT_W] = rank[i*CNT_W +: CNT_W] + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/tsa_alloc.sv
module tsa_alloc
    import tsa_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 5,
    parameter int unsigned TS_W      = 8,
    parameter int unsigned MIN_LAT   = 2,
    parameter int unsigned PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [TS_W-1:0]             cur_time,
    input  logic [NUM_PORTS-1:0]        req_valid,
    input  logic [NUM_PORTS*PORT_W-1:0] req_port,
    output logic [NUM_PORTS-1:0]        ts_valid,
    output logic [NUM_PORTS*TS_W-1:0]   ts_value
);
    localparam int unsigned CNT_W = cnt_width(NUM_PORTS);

    logic [NUM_PORTS-1:0]       legal;
    logic [NUM_PORTS-1:0]       hit_a  [NUM_PORTS];
    logic [TS_W-1:0]            base_a [NUM_PORTS];
    logic [NUM_PORTS*CNT_W-1:0] rank;
    logic [NUM_PORTS*TS_W-1:0]  stamp;

    genvar gi, go;
    generate
        for (gi = 0; gi < NUM_PORTS; gi++) begin : g_in
            assign legal[gi] = req_valid[gi] &&
                ({1'b0, req_port[gi*PORT_W +: PORT_W]} < (PORT_W+1)'(NUM_PORTS));

            always_comb begin
                logic [TS_W-1:0] sel;
                sel = '0;
                for (int o = 0; o < NUM_PORTS; o++) begin
                    if (req_port[gi*PORT_W +: PORT_W] == PORT_W'(o))
                        sel = base_a[o];
                end
                stamp[gi*TS_W +: TS_W] = sel + TS_W'(rank[gi*CNT_W +: CNT_W]);
            end
        end

        for (go = 0; go < NUM_PORTS; go++) begin : g_out
            for (gi = 0; gi < NUM_PORTS; gi++) begin : g_hit
                assign hit_a[go][gi] = legal[gi] &&
                    (req_port[gi*PORT_W +: PORT_W] == PORT_W'(go));
            end

            tsa_lane #(
                .NUM_PORTS(NUM_PORTS),
                .TS_W     (TS_W),
                .MIN_LAT  (MIN_LAT)
            ) u_lane (
                .clk     (clk),
                .rst     (rst),
                .cur_time(cur_time),
                .hit     (hit_a[go]),
                .base    (base_a[go])
            );
        end
    endgenerate

    tsa_rank #(
        .NUM_PORTS(NUM_PORTS),
        .PORT_W   (PORT_W),
        .CNT_W    (CNT_W)
    ) u_rank (
        .legal(legal),
        .port (req_port),
        .rank (rank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_valid <= '0;
            ts_value <= '0;
        end else begin
            ts_valid <= legal;
            ts_value <= stamp;
        end
    end

endmodule

// File: rtl/tsa_alloc_chk.sv
module tsa_alloc_chk #(
    parameter int unsigned NUM_PORTS = 5,
    parameter int unsigned TS_W      = 8,
    parameter int unsigned MIN_LAT   = 2,
    parameter int unsigned PORT_W    = 3
) (
    input logic                        clk,
    input logic                        rst,
    input logic [TS_W-1:0]             cur_time,
    input logic [NUM_PORTS-1:0]        req_valid,
    input logic [NUM_PORTS*PORT_W-1:0] req_port,
    input logic [NUM_PORTS-1:0]        ts_valid,
    input logic [NUM_PORTS*TS_W-1:0]   ts_value
);
    logic                        rst_q;
    logic [TS_W-1:0]             cur_q;
    logic [NUM_PORTS-1:0]        req_q;
    logic [NUM_PORTS*PORT_W-1:0] port_q;

    always_ff @(posedge clk) begin
        rst_q  <= rst;
        cur_q  <= cur_time;
        req_q  <= req_valid;
        port_q <= req_port;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst_q |-> (ts_valid == '0));

    genvar gi, gj;
    generate
        for (gi = 0; gi < NUM_PORTS; gi++) begin : g_i
            logic [TS_W-1:0] lead;
            logic            port_bad;
            assign lead     = ts_value[gi*TS_W +: TS_W] - cur_q - TS_W'(MIN_LAT);
            assign port_bad = ({1'b0, port_q[gi*PORT_W +: PORT_W]} >= (PORT_W+1)'(NUM_PORTS));

            // R2
            valid_from_req_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
                ts_valid[gi] |-> req_q[gi]);

            // R8
            bad_port_drop_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
                (req_q[gi] && port_bad) |-> !ts_valid[gi]);

            // R3
            floor_respected_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
                ts_valid[gi] |-> !lead[TS_W-1]);

            for (gj = gi + 1; gj < NUM_PORTS; gj++) begin : g_j
                logic [TS_W-1:0] step;
                assign step = ts_value[gj*TS_W +: TS_W] - ts_value[gi*TS_W +: TS_W];

                // R4
                index_order_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
                    (ts_valid[gi] && ts_valid[gj] &&
                     port_q[gi*PORT_W +: PORT_W] == port_q[gj*PORT_W +: PORT_W])
                    |-> (step != '0 && !step[TS_W-1]));
            end
        end
    endgenerate

endmodule

bind tsa_alloc tsa_alloc_chk #(
    .NUM_PORTS(NUM_PORTS),
    .TS_W     (TS_W),
    .MIN_LAT  (MIN_LAT),
    .PORT_W   (PORT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cur_time (cur_time),
    .req_valid(req_valid),
    .req_port (req_port),
    .ts_valid (ts_valid),
    .ts_value (ts_value)
);

// File: tb/tsa_alloc_bench.sv
module tsa_alloc_bench;
    localparam int unsigned NP = 5;
    localparam int unsigned TW = 8;
    localparam int unsigned ML = 2;
    localparam int unsigned PW = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [TW-1:0]    cur_time = 8'd200;
    logic [NP-1:0]    req_valid = '0;
    logic [NP*PW-1:0] req_port = '0;
    logic [NP-1:0]    ts_valid;
    logic [NP*TW-1:0] ts_value;

    int n_checks = 0;
    int n_fail   = 0;
    logic [TW-1:0] tnow = 8'd200;

    always #10 clk = ~clk;

    tsa_alloc #(.NUM_PORTS(NP), .TS_W(TW), .MIN_LAT(ML), .PORT_W(PW)) u_tsa_alloc (
        .clk(clk), .rst(rst), .cur_time(cur_time), .req_valid(req_valid),
        .req_port(req_port), .ts_valid(ts_valid), .ts_value(ts_value)
    );

    task automatic adv();
        @(negedge clk);
        tnow      = tnow + 8'd1;
        cur_time  = tnow;
        req_valid = '0;
        req_port  = '0;
    endtask

    task automatic put(input int i, input int p);
        req_valid[i]         = 1'b1;
        req_port[i*PW +: PW] = PW'(p);
    endtask

    task automatic chk(input int i, input logic ev, input logic [TW-1:0] ets, input string tag);
        n_checks++;
        if (ts_valid[i] !== ev || (ev && ts_value[i*TW +: TW] !== ets)) begin
            n_fail++;
            $display("FAIL %s input %0d: got valid=%b ts=%0d, expected valid=%b ts=%0d",
                     tag, i, ts_valid[i], ts_value[i*TW +: TW], ev, ets);
        end
    endtask

    task automatic t_reset();
        logic [TW-1:0] t0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NP; i++) chk(i, 1'b0, '0, "R1 reset quiet");
        adv();
        put(3, 1);
        t0 = tnow;
        adv();
        chk(3, 1'b1, t0 + 8'(ML), "R1 first stamp after reset");
    endtask

    task automatic t_single();
        logic [TW-1:0] t0;
        adv();
        put(0, 4);
        t0 = tnow;
        adv();
        chk(0, 1'b1, t0 + 8'(ML), "R3 idle output floor");
        chk(1, 1'b0, '0, "R2 no request no stamp");
    endtask

    task automatic t_burst();
        logic [TW-1:0] t0;
        adv();
        for (int i = 0; i < NP; i++) put(i, 2);
        t0 = tnow;
        adv();
        for (int i = 0; i < NP; i++) chk(i, 1'b1, t0 + 8'(ML) + 8'(i), "R4 same-cycle index order");
        put(0, 2);
        adv();
        chk(0, 1'b1, t0 + 8'(ML) + 8'(NP), "R5 backlog continues");
    endtask

    task automatic t_indep();
        logic [TW-1:0] t0;
        adv();
        put(0, 3);
        put(1, 4);
        t0 = tnow;
        adv();
        chk(0, 1'b1, t0 + 8'(ML), "R6 output 3 independent");
        chk(1, 1'b1, t0 + 8'(ML), "R6 output 4 independent");
    endtask

    task automatic t_badport();
        logic [TW-1:0] t0;
        adv();
        put(2, 5);
        put(3, 7);
        put(4, 0);
        t0 = tnow;
        adv();
        chk(2, 1'b0, '0, "R8 port 5 ignored");
        chk(3, 1'b0, '0, "R8 port 7 ignored");
        chk(4, 1'b1, t0 + 8'(ML), "R8 no rank shift");
    endtask

    task automatic t_wrap();
        while (tnow != 8'd249) adv();
        adv();
        for (int i = 0; i < NP; i++) put(i, 1);
        adv();
        for (int i = 0; i < NP; i++) chk(i, 1'b1, 8'd252 + 8'(i), "R7 burst across wrap");
        put(0, 1);
        adv();
        chk(0, 1'b1, 8'd1, "R7 wrapped backlog is later");
    endtask

    task automatic t_stale();
        logic [TW-1:0] t0;
        repeat (150) adv();
        put(1, 1);
        t0 = tnow;
        adv();
        chk(1, 1'b1, t0 + 8'(ML), "R3 long idle returns to floor");
    endtask

    initial begin
        t_reset();
        t_single();
        t_burst();
        t_indep();
        t_badport();
        t_wrap();
        t_stale();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule